// File: doc/BRIEF.md
# Asynchronous NOR Bus Front End

This block sits at the pins of a parallel NOR-style memory. It runs on a fast internal clock and turns the asynchronous active-low strobes into clean internal events. The strobes are chip select (`ce_n`), output enable (`oe_n`) and write strobe (`we_n`). The address and data buses are sampled along with them. Every strobe goes through a two-flop synchroniser and then a stability filter, so a pulse shorter than the filter window never reaches the decoder.

From the filtered strobes the block classifies the current bus state as standby, output-disabled, read or write.

- **Writes:** the address is latched when the later of chip select and write strobe goes active. The data is latched when the first of them goes inactive. At that moment one single-cycle event is handed to the downstream command interpreter.
- **Reads:** the data bus is driven with array data taken from an input port, or with one of two identification codes when identification mode is selected. A separate output-enable signal controls the tristate driver.
- **Idle detection:** an idle counter raises an automatic-standby flag after a programmable number of quiet cycles.

Top module: `nor_bus_front`

## Requirements
- R1: While and after reset, `standby` is 1, `dq_oe` is 0, `wr_valid` is 0, `auto_stby` is 0 and `bus_op` is 0.
- R2: When chip select and output enable are low and the write strobe is high, `dq_oe` is 1 and `dq_out` carries `array_rdata` for the address presented on `rd_addr`.
- R3: Whenever output enable is high, `dq_oe` is 0 regardless of the other strobes.
- R4: Whenever chip select is high, `standby` is 1 and `dq_oe` is 0.
- R5: For a write, `wr_addr` equals the address present when the later of chip select and write strobe went low, whichever of the two falls last.
- R6: For a write, `wr_data` equals the data present when the first of chip select and write strobe goes high. Exactly one `wr_valid` pulse, one clock wide, is produced per write.
- R7: A write during which output enable goes low produces no `wr_valid` pulse.
- R8: A strobe pulse of a single clock period on chip select or write strobe is ignored. It starts no write, ends no read and does not change `bus_op`.
- R9: After `IDLE_CYC` clock cycles with no change on any strobe or on the address bus, `auto_stby` is 1.
- R10: Any change on the address bus or on a strobe clears `auto_stby` within a few cycles.
- R11: A read in progress keeps `dq_oe` at 1 and keeps returning data while `auto_stby` is 1.
- R12: With `id_mode` 1, a read returns `MFR_CODE` (default 0020h) when address bits 1:0 are 00, and `DEV_CODE` (default 88ABh) when they are 01. All higher address bits are ignored.
- R13: `bus_op` encodes standby as 0, output-disabled as 1, read as 2 and write as 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Asynchronous chip select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| we_n | input | 1 | Asynchronous write strobe, active low |
| addr | input | 20 | Asynchronous address bus |
| dq_in | input | 16 | Data bus input side |
| id_mode | input | 1 | Selects identification codes for reads |
| array_rdata | input | 16 | Array read data for `rd_addr` |
| rd_addr | output | 20 | Synchronised address to the array |
| dq_out | output | 16 | Data bus output side |
| dq_oe | output | 1 | Tristate driver enable for `dq_out` |
| standby | output | 1 | Chip is deselected |
| auto_stby | output | 1 | Bus idle long enough for automatic standby |
| bus_op | output | 2 | Decoded bus state |
| wr_valid | output | 1 | Single-cycle write event |
| wr_addr | output | 20 | Latched write address |
| wr_data | output | 16 | Latched write data |

## Verification
The checks assume that the address and data buses are stable for several clock cycles around every strobe transition. This lets the two-cycle synchroniser deliver settled values at the moment the filtered strobe edges act on them. They also assume that a real strobe level lasts at least two clock samples, and that an end-of-write is never followed by a new write within one cycle. The stimulus changes the buses only at falling clock edges, holds each value at least eight cycles around strobe edges, and makes glitches exactly one clock period wide.

// File: rtl/nbf_pkg.sv
// Shared types for the NOR bus front end.
// Assumes: bus state encoding is visible at the top-level port bus_op.
package nbf_pkg;
    typedef enum logic [1:0] {
        OP_STANDBY = 2'd0,
        OP_DISABLE = 2'd1,
        OP_READ    = 2'd2,
        OP_WRITE   = 2'd3
    } bus_op_e;

    localparam int STROBE_N = 3;
    localparam int IDX_CE   = 0;
    localparam int IDX_OE   = 1;
    localparam int IDX_WE   = 2;
endpackage

// File: rtl/strobe_filter.sv
// Synchronises and de-glitches a vector of asynchronous active-low strobes.
// Assumes: a real level persists for STABLE_CYC samples; shorter pulses are dropped.
// Reset value of every filtered strobe is the inactive (high) level.
module strobe_filter #(
    parameter int WIDTH      = 3,
    parameter int STABLE_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] strobe_async,
    output logic [WIDTH-1:0] strobe_filt
);
    localparam int CW = $clog2(STABLE_CYC + 1);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic          meta_q, sync_q;
        logic [CW-1:0] cnt_q;

        // Two-flop synchroniser for this strobe
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
            end else begin
                meta_q <= strobe_async[i];
                sync_q <= meta_q;
            end
        end

        // Accept a new level only after it is seen STABLE_CYC samples in a row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q          <= '0;
                strobe_filt[i] <= 1'b1;
            end else if (sync_q == strobe_filt[i]) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(STABLE_CYC - 1)) begin
                cnt_q          <= '0;
                strobe_filt[i] <= sync_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bus_idle_timer.sv
// Counts cycles with no strobe or address activity and raises auto standby.
// Assumes: inputs are already synchronous; any change restarts the count.
module bus_idle_timer #(
    parameter int ADDR_W   = 20,
    parameter int IDLE_CYC = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        strobes,
    input  logic [ADDR_W-1:0] addr_s,
    output logic              auto_stby
);
    localparam int CW = $clog2(IDLE_CYC + 1);

    logic [2:0]        strobes_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CW-1:0]     idle_q;
    logic              activity;

    // Remember last seen bus values for change detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobes_q <= 3'b111;
            addr_q    <= '0;
        end else begin
            strobes_q <= strobes;
            addr_q    <= addr_s;
        end
    end

    assign activity = (strobes != strobes_q) || (addr_s != addr_q);

    // Idle counter; flag asserts once the count reaches its limit
    always_ff @(posedge clk) begin
        if (!rst_n || activity) begin
            idle_q    <= '0;
            auto_stby <= 1'b0;
        end else if (idle_q == CW'(IDLE_CYC - 1)) begin
            auto_stby <= 1'b1;
        end else begin
            idle_q <= idle_q + 1'b1;
        end
    end
endmodule

// File: rtl/write_capture.sv
// Tracks a write window (chip select and write strobe both low), latches the
// address when the window opens and the data when it closes.
// Assumes: filtered strobes; output enable low anywhere in the window voids it.
module write_capture #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_f,
    input  logic              oe_f,
    input  logic              we_f,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic win, win_q, void_q;

    assign win = !ce_f && !we_f;

    // Window state, address latch at opening and void tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q   <= 1'b0;
            void_q  <= 1'b0;
            wr_addr <= '0;
        end else begin
            win_q <= win;
            if (win && !win_q) begin
                wr_addr <= addr_s;
                void_q  <= !oe_f;
            end else if (win && !oe_f) begin
                void_q <= 1'b1;
            end
        end
    end

    // Data latch and single write event at window close
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (win_q && !win) begin
                wr_data  <= data_s;
                wr_valid <= !void_q;
            end
        end
    end
endmodule

// File: rtl/nor_bus_front.sv
// Device-side front end of an asynchronous parallel NOR memory bus.
// Synchronises the pins, de-glitches strobes, decodes the bus state, captures
// writes, drives read or identification data and flags automatic standby.
// Assumes: address and data settle before the strobe edges that use them.
module nor_bus_front #(
    parameter int          ADDR_W     = 20,
    parameter int          DATA_W     = 16,
    parameter int          STABLE_CYC = 2,
    parameter int          IDLE_CYC   = 30,
    parameter logic [15:0] MFR_CODE   = 16'h0020,
    parameter logic [15:0] DEV_CODE   = 16'h88AB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    input  logic              id_mode,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              standby,
    output logic              auto_stby,
    output logic [1:0]        bus_op,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    import nbf_pkg::*;

    logic [STROBE_N-1:0] strobe_f;
    logic                ce_f, oe_f, we_f;
    logic [ADDR_W-1:0]   addr_m, addr_s;
    logic [DATA_W-1:0]   data_m, data_s;
    bus_op_e             op;
    logic [DATA_W-1:0]   rd_word;

    strobe_filter #(.WIDTH(STROBE_N), .STABLE_CYC(STABLE_CYC)) u_filt (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_async({we_n, oe_n, ce_n}),
        .strobe_filt (strobe_f)
    );

    assign ce_f = strobe_f[IDX_CE];
    assign oe_f = strobe_f[IDX_OE];
    assign we_f = strobe_f[IDX_WE];

    // Two-flop synchronisers for the address and data buses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_m <= '0;
            addr_s <= '0;
            data_m <= '0;
            data_s <= '0;
        end else begin
            addr_m <= addr;
            addr_s <= addr_m;
            data_m <= dq_in;
            data_s <= data_m;
        end
    end

    // Bus state decode from filtered strobes
    always_comb begin
        if (ce_f)              op = OP_STANDBY;
        else if (oe_f && !we_f) op = OP_WRITE;
        else if (!oe_f && we_f) op = OP_READ;
        else                    op = OP_DISABLE;
    end

    // Read word mux: identification codes or array data
    always_comb begin
        if (!id_mode)                 rd_word = array_rdata;
        else if (addr_s[1:0] == 2'b00) rd_word = DATA_W'(MFR_CODE);
        else if (addr_s[1:0] == 2'b01) rd_word = DATA_W'(DEV_CODE);
        else                           rd_word = '0;
    end

    // Registered data bus output and tristate enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_oe  <= 1'b0;
            dq_out <= '0;
        end else begin
            dq_oe  <= (op == OP_READ);
            dq_out <= rd_word;
        end
    end

    write_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_f    (ce_f),
        .oe_f    (oe_f),
        .we_f    (we_f),
        .addr_s  (addr_s),
        .data_s  (data_s),
        .wr_valid(wr_valid),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    bus_idle_timer #(.ADDR_W(ADDR_W), .IDLE_CYC(IDLE_CYC)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobes  (strobe_f),
        .addr_s   (addr_s),
        .auto_stby(auto_stby)
    );

    assign rd_addr = addr_s;
    assign standby = ce_f;
    assign bus_op  = op;
endmodule

// File: rtl/nbf_chk.sv
// Property checker for nor_bus_front, attached by bind.
// Assumes: observes filtered strobes and synchronised address inside the top.
module nbf_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_f,
    input logic              oe_f,
    input logic              we_f,
    input logic [ADDR_W-1:0] addr_s,
    input logic              dq_oe,
    input logic              wr_valid,
    input logic              auto_stby
);
    // R3
    oe_high_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_f |=> !dq_oe);

    // R4
    ce_high_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_f |=> !dq_oe);

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R6
    pulse_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (ce_f || we_f));

    // R7
    pulse_needs_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> oe_f);

    // R10
    addr_change_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_s != $past(addr_s)) |=> !auto_stby);
endmodule

bind nor_bus_front nbf_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_f     (ce_f),
    .oe_f     (oe_f),
    .we_f     (we_f),
    .addr_s   (addr_s),
    .dq_oe    (dq_oe),
    .wr_valid (wr_valid),
    .auto_stby(auto_stby)
);

// File: tb/nor_bus_front_bench.sv
`timescale 1ns/1ps
module nor_bus_front_bench;
    localparam int CLK_PERIOD = 5;
    localparam int IDLE_CYC   = 30;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ce_n, oe_n, we_n, id_mode;
    logic [19:0] addr;
    logic [15:0] dq_in, array_rdata;
    logic [19:0] rd_addr, wr_addr;
    logic [15:0] dq_out, wr_data;
    logic        dq_oe, standby, auto_stby, wr_valid;
    logic [1:0]  bus_op;

    int tests = 0, fails = 0, wr_cnt = 0;
    logic [19:0] cap_addr;
    logic [15:0] cap_data;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    assign array_rdata = rd_addr[15:0] ^ 16'h5A5A;

    nor_bus_front u_nor_bus_front (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .id_mode(id_mode), .array_rdata(array_rdata),
        .rd_addr(rd_addr), .dq_out(dq_out), .dq_oe(dq_oe), .standby(standby),
        .auto_stby(auto_stby), .bus_op(bus_op), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // Write event monitor
    always @(negedge clk) begin
        if (wr_valid) begin
            wr_cnt   <= wr_cnt + 1;
            cap_addr <= wr_addr;
            cap_data <= wr_data;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        addr = '0; dq_in = '0; id_mode = 1'b0;
        cyc(4);
        check("R1 standby", standby, 1);
        check("R1 dq_oe", dq_oe, 0);
        check("R1 wr_valid", wr_valid, 0);
        check("R1 auto_stby", auto_stby, 0);
        check("R1 bus_op", bus_op, 0);
        rst_n = 1'b1;
        cyc(3);
        check("R1 dq_oe after release", dq_oe, 0);
    endtask

    task automatic t_read();
        addr = 20'h01234; ce_n = 1'b0; oe_n = 1'b0;
        cyc(8);
        check("R2 dq_oe", dq_oe, 1);
        check("R2 dq_out", dq_out, 16'h1234 ^ 16'h5A5A);
        check("R13 read op", bus_op, 2);
        addr = 20'hF00FF;
        cyc(8);
        check("R2 dq_out new addr", dq_out, 16'h00FF ^ 16'h5A5A);
    endtask

    task automatic t_out_disable();
        oe_n = 1'b1;
        cyc(8);
        check("R3 dq_oe", dq_oe, 0);
        check("R13 disable op", bus_op, 1);
    endtask

    task automatic t_standby();
        oe_n = 1'b0; ce_n = 1'b1;
        cyc(8);
        check("R4 dq_oe", dq_oe, 0);
        check("R4 standby", standby, 1);
        check("R13 standby op", bus_op, 0);
        oe_n = 1'b1;
        cyc(8);
    endtask

    task automatic t_write_we_first();
        int base = wr_cnt;
        addr = 20'h0AAAA; dq_in = 16'hC0DE; we_n = 1'b0;
        cyc(10);
        addr = 20'h05555; ce_n = 1'b0;
        cyc(10);
        check("R13 write op", bus_op, 3);
        we_n = 1'b1;
        cyc(10);
        dq_in = 16'hDEAD; ce_n = 1'b1;
        cyc(10);
        check("R6 one pulse", wr_cnt - base, 1);
        check("R5 addr at last fall", cap_addr, 20'h05555);
        check("R6 data at first rise", cap_data, 16'hC0DE);
    endtask

    task automatic t_write_ce_first();
        int base = wr_cnt;
        addr = 20'h11111; dq_in = 16'h1357; ce_n = 1'b0;
        cyc(10);
        addr = 20'h22222; we_n = 1'b0;
        cyc(10);
        ce_n = 1'b1;
        cyc(10);
        dq_in = 16'h9999; we_n = 1'b1;
        cyc(10);
        check("R6 one pulse ce-first", wr_cnt - base, 1);
        check("R5 addr ce-first", cap_addr, 20'h22222);
        check("R6 data ce-first", cap_data, 16'h1357);
    endtask

    task automatic t_write_oe_abort();
        int base = wr_cnt;
        addr = 20'h00042; dq_in = 16'h4242; ce_n = 1'b0; we_n = 1'b0;
        cyc(10);
        oe_n = 1'b0;
        cyc(6);
        oe_n = 1'b1;
        cyc(10);
        ce_n = 1'b1; we_n = 1'b1;
        cyc(10);
        check("R7 no pulse", wr_cnt - base, 0);
    endtask

    task automatic t_glitch();
        int base = wr_cnt;
        ce_n = 1'b0;
        cyc(8);
        we_n = 1'b0;
        cyc(1);
        we_n = 1'b1;
        cyc(10);
        check("R8 we glitch no write", wr_cnt - base, 0);
        check("R8 op unchanged", bus_op, 1);
        addr = 20'h00777; oe_n = 1'b0;
        cyc(8);
        ce_n = 1'b1;
        cyc(1);
        ce_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            cyc(1);
            check("R8 read held through ce glitch", dq_oe, 1);
        end
        oe_n = 1'b1; ce_n = 1'b1;
        cyc(8);
    endtask

    task automatic t_auto_stby();
        addr = 20'h3C3C3;
        cyc(IDLE_CYC - 8);
        check("R9 not yet idle", auto_stby, 0);
        cyc(20);
        check("R9 idle flag", auto_stby, 1);
        addr = 20'h3C3C4;
        cyc(6);
        check("R10 addr change clears", auto_stby, 0);
        cyc(IDLE_CYC + 10);
        oe_n = 1'b0;
        cyc(8);
        check("R10 strobe change clears", auto_stby, 0);
        oe_n = 1'b1;
        addr = 20'h00ABC; ce_n = 1'b0; oe_n = 1'b0;
        cyc(IDLE_CYC + 12);
        check("R11 idle during read", auto_stby, 1);
        check("R11 still driving", dq_oe, 1);
        check("R11 data kept", dq_out, 16'h0ABC ^ 16'h5A5A);
        ce_n = 1'b1; oe_n = 1'b1;
        cyc(8);
    endtask

    task automatic t_id();
        id_mode = 1'b1; addr = 20'hABC00; ce_n = 1'b0; oe_n = 1'b0;
        cyc(8);
        check("R12 manufacturer code", dq_out, 16'h0020);
        addr = 20'h12341;
        cyc(8);
        check("R12 device code", dq_out, 16'h88AB);
        id_mode = 1'b0;
        cyc(4);
        check("R12 array when not id", dq_out, 16'h2341 ^ 16'h5A5A);
        ce_n = 1'b1; oe_n = 1'b1;
        cyc(8);
    endtask

    initial begin
        t_reset();
        t_read();
        t_out_disable();
        t_standby();
        t_write_we_first();
        t_write_ce_first();
        t_write_oe_abort();
        t_glitch();
        t_auto_stby();
        t_id();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule